// File: doc/BRIEF.md
# Shared FIFO trigger controller

This block holds the byte buffering for a serial controller that contains both a master engine and a slave engine. There are two 8-entry byte FIFOs. The receive FIFO is filled by the protocol side and drained by a data mover. The transmit FIFO is filled by a data mover and drained by whichever engine currently owns it. Each FIFO has its own fill count. A one-cycle flag is raised when a push arrives while the FIFO is full, and another when a pop arrives while it is empty.

A single 32-bit control word is written through a plain write strobe and can be read back at all times. It holds:

- a fill threshold for each FIFO;
- the transmit ownership bit;
- a DMA transmit enable;
- a transmit flush bit that clears itself.

The two threshold comparisons run in opposite directions:

- The receive trigger fires when the FIFO has filled to its threshold or beyond.
- The transmit trigger fires when the FIFO has drained to its threshold or below.

The DMA transmit request is the transmit trigger gated by the enable bit.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00040004 (both thresholds 4, all other bits 0), both counts are 0 and all four error flags are 0.
- R2: The receive FIFO returns bytes in push order and its count stays within 0..8. A push when the count is 8 is dropped and sets `rx_ovf` for the next cycle only. A pop when the count is 0 is ignored and sets `rx_unf` for the next cycle only. When push and pop arrive together, the pop is judged first against the old count.
- R3: The transmit FIFO follows the same ordering, count bounds and `tx_ovf`/`tx_unf` rules as the receive FIFO. These rules apply outside a flush cycle.
- R4: `rx_trig` is 1 exactly when the receive threshold (bits 18:16) is nonzero and `rx_count` is greater than or equal to it. A threshold of 0 never triggers.
- R5: `tx_trig` is 1 exactly when `tx_count` is less than or equal to the transmit threshold (bits 2:0). A threshold of 0 means the FIFO is empty.
- R6: The control word places the receive threshold at bits 18:16, ownership at bit 15, flush at bit 14, DMA enable at bit 13 and the transmit threshold at bits 2:0. Every other bit is written without effect and reads 0.
- R7: Writing 1 to bit 14 makes it read 1 for exactly the next cycle (unless rewritten). At the end of that cycle the transmit FIFO is emptied. Pushes and pops in that cycle are dropped and raise no flag.
- R8: With bit 15 at 0, only `mst_tx_pop` pops the transmit FIFO. With bit 15 at 1, only `slv_tx_pop` does. A pop from the non-owner changes nothing and raises no flag.
- R9: `dma_tx_req` equals `tx_trig` when bit 13 is 1, and is 0 otherwise.
- R10: A threshold written at a clock edge governs the trigger outputs from that edge on, so the new value is visible in the cycle right after the write.
- R11: While a FIFO is not empty, its pop data output presents the oldest stored byte, before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write value |
| reg_rdata | output | 32 | Control word read value |
| rx_push | input | 1 | Receive FIFO push |
| rx_push_data | input | 8 | Receive byte to store |
| rx_pop | input | 1 | Receive FIFO pop |
| rx_pop_data | output | 8 | Oldest receive byte |
| rx_count | output | 4 | Receive fill level 0..8 |
| rx_trig | output | 1 | Receive threshold trigger |
| rx_ovf | output | 1 | Receive push-when-full pulse |
| rx_unf | output | 1 | Receive pop-when-empty pulse |
| tx_push | input | 1 | Transmit FIFO push |
| tx_push_data | input | 8 | Transmit byte to store |
| mst_tx_pop | input | 1 | Transmit pop from master engine |
| slv_tx_pop | input | 1 | Transmit pop from slave engine |
| tx_pop_data | output | 8 | Oldest transmit byte |
| tx_count | output | 4 | Transmit fill level 0..8 |
| tx_trig | output | 1 | Transmit threshold trigger |
| dma_tx_req | output | 1 | DMA transmit request |
| tx_ovf | output | 1 | Transmit push-when-full pulse |
| tx_unf | output | 1 | Transmit pop-when-empty pulse |

## Verification
Most internal faults reach the ports within one clock:

- A wrong fill count shows in `rx_count`/`tx_count` and both triggers one cycle after the bad update.
- A corrupted read or write pointer may stay hidden until that slot becomes the head of the FIFO. It then appears on the pop data output, up to eight pops later.
- A flush bit that fails to clear shows as bit 14 still set two cycles after the write, and as pushes that keep being dropped.
- A wrong ownership choice shows as a count that moves, or fails to move, one cycle after a pop.

Because faults can surface at such different times, every output is compared against a queue-based model on every cycle, rather than only at selected points.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int THR_W      = 3;
  localparam int REG_W      = 32;

  // Control word layout
  localparam int RXTHR_LSB  = 16;
  localparam int OWN_BIT    = 15;
  localparam int FLUSH_BIT  = 14;
  localparam int DMA_BIT    = 13;
  localparam int TXTHR_LSB  = 0;

  localparam logic [THR_W-1:0] THR_RST = THR_W'(4);

  localparam logic [REG_W-1:0] FIELD_MASK =
      (REG_W'((1 << THR_W) - 1) << RXTHR_LSB) |
      (REG_W'(1) << OWN_BIT) | (REG_W'(1) << FLUSH_BIT) | (REG_W'(1) << DMA_BIT) |
      (REG_W'((1 << THR_W) - 1) << TXTHR_LSB);

  typedef struct packed {
    logic [THR_W-1:0] rx_thr;
    logic             tx_own;
    logic             flush;
    logic             dma_en;
    logic [THR_W-1:0] tx_thr;
  } ctrl_t;

  // Receive side: fill has reached the threshold; zero threshold is inert
  function automatic logic rx_fire(input int unsigned fill, input int unsigned thr);
    return (thr != 0) && (fill >= thr);
  endfunction

  // Transmit side: fill has drained to the threshold
  function automatic logic tx_fire(input int unsigned fill, input int unsigned thr);
    return fill <= thr;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[RXTHR_LSB +: THR_W] = c.rx_thr;
    r[OWN_BIT]            = c.tx_own;
    r[FLUSH_BIT]          = c.flush;
    r[DMA_BIT]            = c.dma_en;
    r[TXTHR_LSB +: THR_W] = c.tx_thr;
    return r;
  endfunction
endpackage

// File: rtl/fifo_trig_ctrl_reg.sv
module fifo_trig_ctrl_reg
  import fifo_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rdata
);
  ctrl_t q;
  logic  reserved_unused;

  assign reserved_unused = ^(wdata & ~FIELD_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '{rx_thr: THR_RST, tx_own: 1'b0, flush: 1'b0, dma_en: 1'b0, tx_thr: THR_RST};
    end else if (wr) begin
      q.rx_thr <= wdata[RXTHR_LSB +: THR_W];
      q.tx_own <= wdata[OWN_BIT];
      q.flush  <= wdata[FLUSH_BIT];
      q.dma_en <= wdata[DMA_BIT];
      q.tx_thr <= wdata[TXTHR_LSB +: THR_W];
    end else begin
      q.flush  <= 1'b0;   // flush lasts one cycle
    end
  end

  assign ctrl  = q;
  assign rdata = pack_ctrl(q);
endmodule

// File: rtl/fifo_trig_byte_fifo.sv
module fifo_trig_byte_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      ovf   <= push && full;
      unf   <= pop && empty;
    end
  end

  assign pop_data = mem[rd_ptr];
endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import fifo_trig_pkg::*;
#(
  parameter  int DW    = DATA_W,
  parameter  int DEPTH = FIFO_DEPTH,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rx_push,
  input  logic [DW-1:0]    rx_push_data,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_pop_data,
  output logic [CW-1:0]    rx_count,
  output logic             rx_trig,
  output logic             rx_ovf,
  output logic             rx_unf,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_push_data,
  input  logic             mst_tx_pop,
  input  logic             slv_tx_pop,
  output logic [DW-1:0]    tx_pop_data,
  output logic [CW-1:0]    tx_count,
  output logic             tx_trig,
  output logic             dma_tx_req,
  output logic             tx_ovf,
  output logic             tx_unf
);
  ctrl_t ctrl;
  logic  flush_active;
  logic  tx_pop_sel;

  fifo_trig_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .ctrl  (ctrl),
    .rdata (reg_rdata)
  );

  assign flush_active = ctrl.flush;
  assign tx_pop_sel   = ctrl.tx_own ? slv_tx_pop : mst_tx_pop;

  fifo_trig_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (1'b0),
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_pop),
    .pop_data  (rx_pop_data),
    .count     (rx_count),
    .ovf       (rx_ovf),
    .unf       (rx_unf)
  );

  fifo_trig_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush_active),
    .push      (tx_push),
    .push_data (tx_push_data),
    .pop       (tx_pop_sel),
    .pop_data  (tx_pop_data),
    .count     (tx_count),
    .ovf       (tx_ovf),
    .unf       (tx_unf)
  );

  assign rx_trig    = rx_fire(32'(rx_count), 32'(ctrl.rx_thr));
  assign tx_trig    = tx_fire(32'(tx_count), 32'(ctrl.tx_thr));
  assign dma_tx_req = tx_trig && ctrl.dma_en;
endmodule

// File: rtl/fifo_trig_chk.sv
module fifo_trig_chk
  import fifo_trig_pkg::*;
#(
  parameter  int DW    = DATA_W,
  parameter  int DEPTH = FIFO_DEPTH,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [CW-1:0]    rx_count,
  input logic             rx_trig,
  input logic             rx_ovf,
  input logic             rx_unf,
  input logic             tx_push,
  input logic             mst_tx_pop,
  input logic             slv_tx_pop,
  input logic [CW-1:0]    tx_count,
  input logic             tx_trig,
  input logic             dma_tx_req,
  input logic             tx_ovf,
  input logic             tx_unf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [THR_W-1:0] rx_thr_rd;
  logic             flushing, owner_slv;
  assign rx_thr_rd = reg_rdata[RXTHR_LSB +: THR_W];
  assign flushing  = reg_rdata[FLUSH_BIT];
  assign owner_slv = reg_rdata[OWN_BIT];

  a_r2_rx_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= FULL);
  a_r2_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count == FULL) |=> rx_ovf);
  a_r2_rx_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_count == '0) |=> rx_unf);
  a_r3_tx_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= FULL);
  a_r3_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_count == FULL && !flushing) |=> tx_ovf);
  a_r4_rx_zero_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_thr_rd == '0) |-> !rx_trig);
  a_r4_rx_full_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == FULL && rx_thr_rd != '0) |-> rx_trig);
  a_r5_tx_empty_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> tx_trig);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> (tx_count == '0 && !tx_ovf && !tx_unf));
  a_r7_flush_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing && !reg_wr) |=> !reg_rdata[FLUSH_BIT]);
  a_r8_non_owner_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_slv && slv_tx_pop && !mst_tx_pop && !tx_push && !flushing)
      |=> ($stable(tx_count) && !tx_unf));
  a_r9_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> (tx_trig && reg_rdata[DMA_BIT]));
  a_r10_thr_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[RXTHR_LSB +: THR_W] == $past(reg_wdata[RXTHR_LSB +: THR_W]) &&
                reg_rdata[TXTHR_LSB +: THR_W] == $past(reg_wdata[TXTHR_LSB +: THR_W])));
endmodule

bind fifo_trig_ctrl fifo_trig_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/fifo_trig_ctrl_tb.sv
module fifo_trig_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0]  rx_push_data = '0, rx_pop_data;
  logic [3:0]  rx_count, tx_count;
  logic        rx_trig, rx_ovf, rx_unf;
  logic        tx_push = 1'b0, mst_tx_pop = 1'b0, slv_tx_pop = 1'b0;
  logic [7:0]  tx_push_data = '0, tx_pop_data;
  logic        tx_trig, dma_tx_req, tx_ovf, tx_unf;

  fifo_trig_ctrl u_dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  int m_rxthr = 4, m_txthr = 4, m_own = 0, m_flush = 0, m_dma = 0;
  int m_rx_ovf = 0, m_rx_unf = 0, m_tx_ovf = 0, m_tx_unf = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_wdata = '0;
    rx_push = 1'b0; rx_pop = 1'b0; rx_push_data = '0;
    tx_push = 1'b0; tx_push_data = '0; mst_tx_pop = 1'b0; slv_tx_pop = 1'b0;
  endtask

  task automatic model_update();
    int rsz, tsz, tp;
    rsz = rxq.size();
    m_rx_ovf = 0; m_rx_unf = 0;
    if (rx_pop) begin
      if (rsz > 0) void'(rxq.pop_front()); else m_rx_unf = 1;
    end
    if (rx_push) begin
      if (rsz < 8) rxq.push_back(rx_push_data); else m_rx_ovf = 1;
    end
    m_tx_ovf = 0; m_tx_unf = 0;
    if (m_flush != 0) begin
      txq.delete();
    end else begin
      tsz = txq.size();
      tp = (m_own != 0) ? int'(slv_tx_pop) : int'(mst_tx_pop);
      if (tp != 0) begin
        if (tsz > 0) void'(txq.pop_front()); else m_tx_unf = 1;
      end
      if (tx_push) begin
        if (tsz < 8) txq.push_back(tx_push_data); else m_tx_ovf = 1;
      end
    end
    if (reg_wr) begin
      m_rxthr = int'(reg_wdata[18:16]);
      m_own   = int'(reg_wdata[15]);
      m_flush = int'(reg_wdata[14]);
      m_dma   = int'(reg_wdata[13]);
      m_txthr = int'(reg_wdata[2:0]);
    end else begin
      m_flush = 0;
    end
  endtask

  task automatic compare();
    int exp_rd, exp_rt, exp_tt;
    exp_rd = (m_rxthr << 16) | (m_own << 15) | (m_flush << 14) | (m_dma << 13) | m_txthr;
    exp_rt = (m_rxthr != 0 && rxq.size() >= m_rxthr) ? 1 : 0;
    exp_tt = (txq.size() <= m_txthr) ? 1 : 0;
    chk("R6 R10", "reg_rdata", int'(reg_rdata), exp_rd);
    chk("R2", "rx_count", int'(rx_count), rxq.size());
    chk("R2", "rx_ovf", int'(rx_ovf), m_rx_ovf);
    chk("R2", "rx_unf", int'(rx_unf), m_rx_unf);
    chk("R3", "tx_count", int'(tx_count), txq.size());
    chk("R3", "tx_ovf", int'(tx_ovf), m_tx_ovf);
    chk("R3", "tx_unf", int'(tx_unf), m_tx_unf);
    chk("R4 R10", "rx_trig", int'(rx_trig), exp_rt);
    chk("R5 R10", "tx_trig", int'(tx_trig), exp_tt);
    chk("R9", "dma_tx_req", int'(dma_tx_req), exp_tt & m_dma);
    if (rxq.size() > 0) chk("R11", "rx_pop_data", int'(rx_pop_data), int'(rxq[0]));
    if (txq.size() > 0) chk("R11", "tx_pop_data", int'(tx_pop_data), int'(txq[0]));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    reg_wr = 1'b1; reg_wdata = v; step();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", "reset reg_rdata", int'(reg_rdata), 32'h0004_0004);
    chk("R1", "reset rx_count", int'(rx_count), 0);
    chk("R1", "reset tx_count", int'(tx_count), 0);
    chk("R1", "reset flags", int'({rx_ovf, rx_unf, tx_ovf, tx_unf}), 0);
    compare();
    rst_n = 1'b1;

    // R2 R4: fill receive FIFO past full
    for (int i = 0; i < 9; i++) begin
      rx_push = 1'b1; rx_push_data = 8'(i * 17 + 3); step();
      if (i == 2) chk("R4", "rx_trig at 3 of 4", int'(rx_trig), 0);
      if (i == 3) chk("R4", "rx_trig at 4 of 4", int'(rx_trig), 1);
    end
    chk("R2", "rx overflow pulse", int'(rx_ovf), 1);
    chk("R2", "rx count held at 8", int'(rx_count), 8);
    step();
    chk("R2", "rx overflow one cycle", int'(rx_ovf), 0);
    // R11 R2: drain in order, then underflow
    for (int i = 0; i < 9; i++) begin
      if (i < 8) chk("R11", "rx head", int'(rx_pop_data), (i * 17 + 3) & 8'hFF);
      rx_pop = 1'b1; step();
    end
    chk("R2", "rx underflow pulse", int'(rx_unf), 1);

    // R4: zero receive threshold never triggers
    write_ctrl(32'h0000_0004);
    for (int i = 0; i < 8; i++) begin
      rx_push = 1'b1; rx_push_data = 8'(i); step();
    end
    chk("R4", "rx_trig with threshold 0 and full", int'(rx_trig), 0);
    // R10: threshold change seen the next cycle
    write_ctrl(32'h0007_0000);
    chk("R10", "rx_trig right after threshold 7", int'(rx_trig), 1);
    chk("R6", "reserved bits read zero", int'(reg_rdata & 32'hFFF8_1FF8), 0);
    for (int i = 0; i < 8; i++) begin
      rx_pop = 1'b1; step();
    end

    // R5 R3: transmit threshold 0 and push/pop together on empty
    chk("R5", "tx_trig empty with threshold 0", int'(tx_trig), 1);
    tx_push = 1'b1; tx_push_data = 8'hA5; mst_tx_pop = 1'b1; step();
    chk("R3", "tx pop on empty underflows", int'(tx_unf), 1);
    chk("R5", "tx_trig with 1 byte threshold 0", int'(tx_trig), 0);
    for (int i = 0; i < 8; i++) begin
      tx_push = 1'b1; tx_push_data = 8'(8'h40 + i); step();
    end
    chk("R3", "tx overflow pulse", int'(tx_ovf), 1);

    // R8: non-owner pop ignored
    slv_tx_pop = 1'b1; step();
    chk("R8", "slave pop ignored when master owns", int'(tx_count), 8);
    chk("R8", "no underflow from non-owner", int'(tx_unf), 0);
    write_ctrl(32'h0000_8000 | 32'h0000_2000 | 32'd7);
    mst_tx_pop = 1'b1; step();
    chk("R8", "master pop ignored when slave owns", int'(tx_count), 8);
    slv_tx_pop = 1'b1; step();
    chk("R8", "slave pop accepted when owner", int'(tx_count), 7);
    // R9: DMA request follows trigger when enabled
    chk("R9", "dma_tx_req at 7 of 7", int'(dma_tx_req), 1);

    // R7: flush with a push in the flush cycle
    write_ctrl(32'h0000_4000 | 32'h0000_2000 | 32'd2);
    chk("R7", "flush bit reads 1", int'(reg_rdata[14]), 1);
    tx_push = 1'b1; tx_push_data = 8'h77; step();
    chk("R7", "tx emptied by flush", int'(tx_count), 0);
    chk("R7", "flush bit self-cleared", int'(reg_rdata[14]), 0);
    chk("R7", "no overflow flag from dropped push", int'(tx_ovf), 0);
    chk("R9", "dma_tx_req after flush", int'(dma_tx_req), 1);

    // Mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      rx_push = 1'($urandom_range(0, 1)); rx_push_data = 8'($urandom);
      rx_pop = 1'($urandom_range(0, 1));
      tx_push = 1'($urandom_range(0, 1)); tx_push_data = 8'($urandom);
      mst_tx_pop = 1'($urandom_range(0, 1));
      slv_tx_pop = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) begin
        reg_wr = 1'b1; reg_wdata = $urandom;
      end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule